// File: doc/BRIEF.md
# UART Automatic Hardware Flow Control

This block performs automatic CTS/RTS handshaking for a single UART channel. It sits between the transmit shifter and the receive FIFO. On the transmit side it watches the clear-to-send input and grants or withholds permission for the transmitter to start new characters. On the receive side it compares the FIFO fill level with a programmed trigger level and drives the request-to-send output high to ask the far end to pause.

Each direction has its own enable. With an enable off, that direction falls back to plain behaviour: the CTS input is ignored, and RTS simply follows the software-written value. Automatic RTS takes control only while the software RTS value is low (asserted). A stop requested through CTS never cuts a character short, because the permit signal is frozen while the transmitter reports a character in flight. Each automatic RTS deassertion raises an interrupt request that stays set until a clear pulse.

Both pins are active low: 0 on CTS means the far end accepts data, and 0 on RTS means this end accepts data. All outputs are registered, and reset is synchronous and active high.

Top module: `uart_hwflow`

## Requirements
- R1: In the cycle after reset, tx_permit is 1, rts_out is 1 and flow_irq is 0.
- R2: With auto_cts_en at 0, tx_permit is 1 after any edge where tx_busy is 0, whatever the level of cts_in.
- R3: With auto_cts_en at 1 and tx_busy at 0, tx_permit becomes the inverse of cts_in: a 1 on cts_in stops transmission, and a 0 on cts_in resumes it.
- R4: While tx_busy is 1, tx_permit keeps its value, so the character being shifted out always completes.
- R5: When auto_rts_en is 0, or when sw_rts is 1, rts_out takes the value of sw_rts one edge later, and rx_fill has no effect.
- R6: When auto_rts_en is 1 and sw_rts is 0, rts_out is 1 one edge after rx_fill is greater than or equal to rx_trig.
- R7: Under the conditions of R6, rts_out returns to 0 one edge after rx_fill falls below rx_trig.
- R8: flow_irq goes to 1 on the same edge on which automatic control moves rts_out from 0 to 1.
- R9: flow_irq stays at 1 until an edge where irq_clr is 1 and no new rise occurs. If a new rise and irq_clr happen on the same edge, the rise wins.
- R10: cts_in passes through a two-stage synchronizer. A change on cts_in reaches tx_permit on the third rising edge after it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cts_in | input | 1 | Asynchronous clear-to-send pin, 0 = far end ready |
| auto_cts_en | input | 1 | Enables transmit gating by CTS |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_permit | output | 1 | Transmitter may start a new character |
| auto_rts_en | input | 1 | Enables RTS driven by FIFO level |
| sw_rts | input | 1 | Software RTS value, 0 = asserted |
| rx_fill | input | LVL_W | Current receive FIFO fill |
| rx_trig | input | LVL_W | Programmed trigger level |
| rts_out | output | 1 | Request-to-send pin, 0 = ready to receive |
| irq_clr | input | 1 | Clears the pending flow interrupt |
| flow_irq | output | 1 | Flow-control interrupt request |

## Verification
The embedded properties check on every cycle the following behaviour. The permit holds while a character is in flight. The permit stays open whenever CTS gating is off. RTS tracks the software value whenever automatic mode cannot take control. RTS releases as soon as the fill drops below the trigger. Every interrupt rise coincides with RTS being high. The exact three-edge latency through the synchronizer, the full fill-versus-trigger comparison across all levels, and the rule that a rise wins over a clear on the same edge can only be shown by the bench scenarios. Those scenarios sweep every fill and trigger pair and every combination of CTS, enable and busy.

// File: rtl/uart_hwflow_pkg.sv
package uart_hwflow_pkg;
  typedef enum logic {
    PIN_READY = 1'b0,
    PIN_HOLD  = 1'b1
  } pin_lvl_e;
endpackage

// File: rtl/uart_hwflow_sync.sv
module uart_hwflow_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= 1'b0;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= 1'b0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/uart_hwflow_txgate.sv
module uart_hwflow_txgate
  import uart_hwflow_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cts_sync,
  input  logic auto_cts_en,
  input  logic tx_busy,
  output logic tx_permit
);
  logic stop_req;

  always_comb stop_req = auto_cts_en && (cts_sync == PIN_HOLD);

  always_ff @(posedge clk) begin
    if (rst)           tx_permit <= 1'b1;
    else if (!tx_busy) tx_permit <= !stop_req;
  end

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    tx_busy |=> $stable(tx_permit)); // R4
endmodule

// File: rtl/uart_hwflow_rts.sv
module uart_hwflow_rts
  import uart_hwflow_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_rts_en,
  input  logic             sw_rts,
  input  logic [LVL_W-1:0] rx_fill,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             irq_clr,
  output logic             rts_out,
  output logic             flow_irq
);
  logic auto_on, at_trig, rts_nxt, raise;

  always_comb begin
    auto_on = auto_rts_en && (sw_rts == PIN_READY);
    at_trig = rx_fill >= rx_trig;
    rts_nxt = auto_on ? (at_trig ? PIN_HOLD : PIN_READY) : sw_rts;
    raise   = auto_on && at_trig && (rts_out == PIN_READY);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rts_out  <= PIN_HOLD;
      flow_irq <= 1'b0;
    end else begin
      rts_out <= rts_nxt;
      if (raise)        flow_irq <= 1'b1;
      else if (irq_clr) flow_irq <= 1'b0;
    end
  end

  AST_RTS_SOFT: assert property (@(posedge clk) disable iff (rst)
    (!auto_rts_en || sw_rts) |=> (rts_out == $past(sw_rts))); // R5
  AST_RTS_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (auto_rts_en && !sw_rts && (rx_fill < rx_trig)) |=> !rts_out); // R7
  AST_IRQ_WITH_RTS: assert property (@(posedge clk) disable iff (rst)
    $rose(flow_irq) |-> rts_out); // R8
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !raise) |=> !flow_irq); // R9
endmodule

// File: rtl/uart_hwflow.sv
module uart_hwflow #(
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cts_in,
  input  logic             auto_cts_en,
  input  logic             tx_busy,
  output logic             tx_permit,
  input  logic             auto_rts_en,
  input  logic             sw_rts,
  input  logic [LVL_W-1:0] rx_fill,
  input  logic [LVL_W-1:0] rx_trig,
  output logic             rts_out,
  input  logic             irq_clr,
  output logic             flow_irq
);
  logic cts_sync;

  uart_hwflow_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(cts_in), .q(cts_sync)
  );

  uart_hwflow_txgate u_txgate (
    .clk(clk), .rst(rst), .cts_sync(cts_sync), .auto_cts_en(auto_cts_en),
    .tx_busy(tx_busy), .tx_permit(tx_permit)
  );

  uart_hwflow_rts #(.LVL_W(LVL_W)) u_rts (
    .clk(clk), .rst(rst), .auto_rts_en(auto_rts_en), .sw_rts(sw_rts),
    .rx_fill(rx_fill), .rx_trig(rx_trig), .irq_clr(irq_clr),
    .rts_out(rts_out), .flow_irq(flow_irq)
  );

  AST_CTS_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!auto_cts_en && !tx_busy) |=> tx_permit); // R2
endmodule

// File: tb/uart_hwflow_test.sv
module uart_hwflow_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst, cts_in, auto_cts_en, tx_busy, auto_rts_en, sw_rts, irq_clr;
  logic [LW-1:0] rx_fill, rx_trig;
  logic tx_permit, rts_out, flow_irq;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_hwflow #(.FIFO_DEPTH(DEPTH), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .cts_in(cts_in), .auto_cts_en(auto_cts_en),
    .tx_busy(tx_busy), .tx_permit(tx_permit), .auto_rts_en(auto_rts_en),
    .sw_rts(sw_rts), .rx_fill(rx_fill), .rx_trig(rx_trig),
    .rts_out(rts_out), .irq_clr(irq_clr), .flow_irq(flow_irq)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic exp_p, exp_r, exp_i;
    rst = 1'b1; cts_in = 1'b0; auto_cts_en = 1'b0; tx_busy = 1'b0;
    auto_rts_en = 1'b0; sw_rts = 1'b1; irq_clr = 1'b0;
    rx_fill = '0; rx_trig = LW'(8);
    @(negedge clk);
    tick(2);
    rst = 1'b0;
    check("R1 permit", tx_permit, 1'b1);
    check("R1 rts", rts_out, 1'b1);
    check("R1 irq", flow_irq, 1'b0);

    // CTS sweep over enable, level and busy
    exp_p = 1'b1;
    for (int a = 0; a < 2; a++) begin
      for (int c = 0; c < 2; c++) begin
        for (int b = 0; b < 2; b++) begin
          auto_cts_en = a[0]; cts_in = c[0]; tx_busy = b[0];
          tick(4);
          if (!b[0]) exp_p = !(a[0] && c[0]);
          if (b[0]) check("R4 hold while busy", tx_permit, exp_p);
          else if (a[0]) check("R3 cts gating", tx_permit, exp_p);
          else check("R2 cts ignored", tx_permit, exp_p);
          tx_busy = 1'b0;
          tick(1);
          exp_p = !(a[0] && c[0]);
          check(a[0] ? "R3 after busy" : "R2 after busy", tx_permit, exp_p);
        end
      end
    end

    // Synchronizer latency: exactly three edges
    auto_cts_en = 1'b1; cts_in = 1'b0; tick(4);
    for (int v = 0; v < 4; v++) begin
      cts_in = ~cts_in;
      tick(2);
      check("R10 not before third edge", tx_permit, cts_in);
      tick(1);
      check("R10 at third edge", tx_permit, !cts_in);
    end
    // Stop while busy: character completes, stop applies afterwards
    cts_in = 1'b0; tick(4);
    tx_busy = 1'b1; cts_in = 1'b1; tick(5);
    check("R4 busy keeps permit", tx_permit, 1'b1);
    tx_busy = 1'b0; tick(1);
    check("R3 stop at boundary", tx_permit, 1'b0);
    cts_in = 1'b0; auto_cts_en = 1'b0;

    // Software RTS
    for (int s = 0; s < 2; s++) begin
      for (int f = 0; f <= DEPTH; f += 4) begin
        auto_rts_en = 1'b0; sw_rts = s[0]; rx_fill = LW'(f); tick(1);
        check("R5 sw rts auto off", rts_out, s[0]);
        check("R5 no irq", flow_irq, 1'b0);
      end
    end
    auto_rts_en = 1'b1; sw_rts = 1'b1;
    for (int f = 0; f <= DEPTH; f++) begin
      rx_fill = LW'(f); tick(1);
      check("R5 sw rts high wins", rts_out, 1'b1);
    end

    // Full fill x trigger sweep with bench model
    exp_r = 1'b1; exp_i = 1'b0;
    sw_rts = 1'b0;
    for (int t = 0; t <= DEPTH; t++) begin
      rx_trig = LW'(t);
      for (int f = 0; f <= DEPTH; f++) begin
        rx_fill = LW'(f); tick(1);
        if (!exp_r && (f >= t)) exp_i = 1'b1;
        exp_r = (f >= t);
        if (exp_r) check("R6 rts high at trigger", rts_out, 1'b1);
        else check("R7 rts released", rts_out, 1'b0);
        check("R8 irq on rise", flow_irq, exp_i);
      end
      rx_fill = LW'(DEPTH); irq_clr = 1'b1; tick(1);
      irq_clr = 1'b0; exp_i = 1'b0;
      check("R9 clear", flow_irq, 1'b0);
      exp_r = 1'b1;
    end

    // Pending until cleared; rise beats clear
    rx_trig = LW'(4); rx_fill = LW'(0); tick(1);
    rx_fill = LW'(6); tick(1);
    check("R8 raised", flow_irq, 1'b1);
    rx_fill = LW'(0); tick(3);
    check("R9 pending held", flow_irq, 1'b1);
    rx_fill = LW'(5); irq_clr = 1'b1; tick(1);
    check("R9 rise beats clear", flow_irq, 1'b1);
    irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
    check("R9 cleared", flow_irq, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule